// File: doc/BRIEF.md
# SPI Slave Register Bank

This block is an SPI slave in mode 0 (clock idles low, data is sampled on the rising clock edge and changed on the falling edge). It holds a bank of five 8-bit configuration registers. The system clock oversamples the serial clock, chip select and input data through two-flop synchronizers. Every register's contents appear at all times on a flat parallel output.

A transaction starts when chip select goes low. The first byte is a command: its most significant bit selects the direction and its lower seven bits give a register address. A data byte follows. If chip select stays low, more data bytes can follow without a new command, and the address steps forward after each one. Above the last real register there are three dummy locations. Writes to them are dropped and reads from them return zero. After the dummy locations the address wraps back to zero. The slave drives MISO only during the data bytes of a read. At all other times its output enable is low, so a shared line is left free.

Top module: `spi_regbank`

## Requirements
- R1: After reset every register holds 0x00 and miso_oe_o is low.
- R2: Bits are shifted most significant bit first and are sampled on the rising SCLK edge. In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write, and bits 6..0 hold the start address. A read frame never changes a register.
- R3: In a write frame, a data byte is stored into the addressed register only once its eighth bit has been sampled. Register n appears on regs_o[8n+7:8n].
- R4: In a read frame, each data byte carries the addressed register on MISO, bit 7 first. Each bit is valid before the rising SCLK edge that samples it.
- R5: miso_oe_o is low while chip select is high, during every command byte, and for the whole of a write frame. It is high during the data bytes of a read frame.
- R6: While chip select stays low, further data bytes need no new command, and the address increases by one after each data byte.
- R7: Addresses 5, 6 and 7 are dummy locations. A write to one of them changes no register, and a read from one returns 0x00.
- R8: After a data byte at address 7, the burst continues at address 0.
- R9: Chip select going high drops any partial byte without storing it and clears the bit count, so the next frame always starts with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO driver |
| regs_o | output | NUM_REGS*8 | All register contents, register n at bits 8n+7..8n |

## Verification
Single-byte writes and reads use values that differ from their bit reverses, so a wrong bit order, or a command bit taken as an address bit, shows up as a different value. A nine-byte write burst from address 0 runs across the dummy window and wraps. Only the first five bytes and the ninth may land, which separates correct increment, dropped dummy writes and wrap from an early or late wrap. A read burst that starts at address 3 then shows the zero fill followed by a return to register 0. Frames that are cut off inside the command byte and inside the data byte, each followed by a normal write, show that partial bytes are dropped and that the next frame still starts with a command byte.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int CMD_RD_BIT = 7;
  localparam int CNT_W      = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic  en;
    addr_t addr;
    byte_t data;
  } wr_req_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regbank_pkg::*;
#(
  parameter int NUM_REGS  = 5,
  parameter int NUM_DUMMY = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_n_s_i,
  input  logic    sclk_s_i,
  input  logic    mosi_s_i,
  input  byte_t   rd_data_i,
  output addr_t   addr_o,
  output wr_req_t wr_o,
  output logic    miso_o,
  output logic    miso_oe_o
);
  localparam addr_t WRAP_ADDR = addr_t'(NUM_REGS + NUM_DUMMY - 1);
  localparam cnt_t  LAST_BIT  = cnt_t'(BYTE_W - 1);

  logic              sclk_q;
  cnt_t              bit_cnt_q;
  logic [BYTE_W-2:0] shift_q;
  phase_e            phase_q;
  logic              rd_q;
  addr_t             addr_q;
  byte_t             tx_q;
  logic              oe_q;
  wr_req_t           wr_q;

  logic  rise, fall, byte_done;
  byte_t byte_in;
  addr_t addr_next;

  assign rise      = sclk_s_i & ~sclk_q & ~cs_n_s_i;
  assign fall      = ~sclk_s_i & sclk_q & ~cs_n_s_i;
  assign byte_in   = {shift_q, mosi_s_i};
  assign byte_done = rise && (bit_cnt_q == LAST_BIT);
  assign addr_next = (addr_q == WRAP_ADDR) ? '0 : addr_q + addr_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      phase_q   <= PH_CMD;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      wr_q      <= '0;
    end else begin
      sclk_q  <= sclk_s_i;
      wr_q.en <= 1'b0;
      if (cs_n_s_i) begin
        // frame end: drop partial byte, next byte is a command
        bit_cnt_q <= '0;
        phase_q   <= PH_CMD;
        oe_q      <= 1'b0;
      end else begin
        if (rise) begin
          shift_q   <= byte_in[BYTE_W-2:0];
          bit_cnt_q <= byte_done ? '0 : bit_cnt_q + cnt_t'(1);
        end
        if (byte_done) begin
          if (phase_q == PH_CMD) begin
            rd_q    <= byte_in[CMD_RD_BIT];
            addr_q  <= byte_in[ADDR_W-1:0];
            oe_q    <= byte_in[CMD_RD_BIT];
            phase_q <= PH_DATA;
          end else begin
            if (!rd_q) wr_q <= '{en: 1'b1, addr: addr_q, data: byte_in};
            addr_q <= addr_next;
          end
        end
        if (fall) begin
          // first falling edge of a read data byte loads the register
          if (bit_cnt_q == '0 && phase_q == PH_DATA && rd_q) tx_q <= rd_data_i;
          else tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_o      = wr_q;
  assign miso_o    = tx_q[BYTE_W-1];
  assign miso_oe_o = oe_q;

  a_r5_oe_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !oe_q);
  a_r5_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (rd_q && phase_q == PH_DATA));
  a_r9_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (bit_cnt_q == '0 && phase_q == PH_CMD));
  a_r3_full_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q.en |-> ($past(bit_cnt_q) == LAST_BIT && !$past(cs_n_s_i)));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase_q == PH_DATA && addr_q != WRAP_ADDR) |=> addr_q == $past(addr_q) + addr_t'(1));
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase_q == PH_DATA && addr_q == WRAP_ADDR) |=> addr_q == '0);
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_regbank_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  wr_req_t                    wr_i,
  input  addr_t                      rd_addr_i,
  output byte_t                      rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  byte_t regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (wr_i.en && wr_i.addr == addr_t'(g))  regs_q[g] <= wr_i.data;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
  end

  // unmapped and dummy addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == addr_t'(i)) rd_data_o = regs_q[i];
  end

  a_r7_dummy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.en && wr_i.addr >= addr_t'(NUM_REGS)) |=> $stable(regs_o));
  a_r3_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i.en |=> $stable(regs_o));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regbank_pkg::*;
#(
  parameter int NUM_REGS    = 5,
  parameter int NUM_DUMMY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  output logic                       miso_o,
  output logic                       miso_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [2:0] raw, synced;
  addr_t      addr;
  byte_t      rd_data;
  wr_req_t    wr;

  assign raw = {cs_ni, sclk_i, mosi_i};

  spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  spi_frame #(.NUM_REGS(NUM_REGS), .NUM_DUMMY(NUM_DUMMY)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (synced[2]),
    .sclk_s_i (synced[1]),
    .mosi_s_i (synced[0]),
    .rd_data_i(rd_data),
    .addr_o   (addr),
    .wr_o     (wr),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe_o)
  );

  spi_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .rd_addr_i(addr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system clocks per SCLK half period
  localparam int NREG       = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [NREG*8-1:0] regs;
  logic [7:0] model [NREG];
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .regs_o(regs)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    rx = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso; oe_any |= miso_oe; oe_all &= miso_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < NREG; i++) chk(req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    chk("R1 regs", regs, '0);
    chk("R1 oe", miso_oe, 1'b0);
  endtask

  task automatic t_single_write();
    logic [7:0] rx; logic oa, ol;
    cs_begin();
    xfer(8'h02, 8, rx, oa, ol);
    chk("R5 oe cmd", oa, 1'b0);
    xfer(8'h1E, 8, rx, oa, ol);
    chk("R5 oe write", oa, 1'b0);
    cs_end();
    model[2] = 8'h1E;
    chk_all("R3 single write");
    chk("R5 oe idle", miso_oe, 1'b0);
  endtask

  task automatic t_single_read();
    logic [7:0] rx; logic oa, ol;
    cs_begin();
    xfer(8'h82, 8, rx, oa, ol);
    chk("R5 oe read cmd", oa, 1'b0);
    xfer(8'hFF, 8, rx, oa, ol);
    chk("R4 read data", rx, 8'h1E);
    chk("R5 oe read data", ol, 1'b1);
    cs_end();
    chk_all("R2 read leaves regs");
  endtask

  task automatic t_burst_write();
    logic [7:0] rx; logic oa, ol;
    logic [7:0] d [9] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    cs_begin();
    xfer(8'h00, 8, rx, oa, ol);
    for (int i = 0; i < 9; i++) xfer(d[i], 8, rx, oa, ol);
    cs_end();
    model[0] = 8'h99; model[1] = 8'h22; model[2] = 8'h33; model[3] = 8'h44; model[4] = 8'h55;
    chk("R6 inc reg1", regs[15:8], 8'h22);
    chk("R6 inc reg4", regs[39:32], 8'h55);
    chk("R8 wrap reg0", regs[7:0], 8'h99);
    chk_all("R7 dummy writes dropped");
  endtask

  task automatic t_burst_read();
    logic [7:0] rx; logic oa, ol;
    logic [7:0] e [7];
    e = '{model[3], model[4], 8'h00, 8'h00, 8'h00, model[0], model[1]};
    cs_begin();
    xfer(8'h83, 8, rx, oa, ol);
    for (int i = 0; i < 7; i++) begin
      xfer(8'h00, 8, rx, oa, ol);
      if (i >= 2 && i <= 4) chk("R7 dummy read zero", rx, 8'h00);
      else if (i >= 5)      chk("R8 read after wrap", rx, e[i]);
      else                  chk("R6 burst read", rx, e[i]);
      chk("R4 oe burst", ol, 1'b1);
    end
    cs_end();
  endtask

  task automatic t_abort();
    logic [7:0] rx; logic oa, ol;
    cs_begin();
    xfer(8'h01, 8, rx, oa, ol);
    xfer(8'hE7, 5, rx, oa, ol);
    cs_end();
    chk_all("R9 partial data dropped");
    cs_begin();
    xfer(8'h80, 3, rx, oa, ol);
    cs_end();
    cs_begin();
    xfer(8'h04, 8, rx, oa, ol);
    xfer(8'h5A, 8, rx, oa, ol);
    cs_end();
    model[4] = 8'h5A;
    chk("R9 restart at command", regs[39:32], 8'h5A);
    chk_all("R9 others intact");
  endtask

  task automatic t_dummy_direct();
    logic [7:0] rx; logic oa, ol;
    cs_begin();
    xfer(8'h06, 8, rx, oa, ol);
    xfer(8'hFF, 8, rx, oa, ol);
    cs_end();
    chk_all("R7 direct dummy write");
    cs_begin();
    xfer(8'h85, 8, rx, oa, ol);
    xfer(8'h00, 8, rx, oa, ol);
    chk("R7 direct dummy read", rx, 8'h00);
    xfer(8'h00, 8, rx, oa, ol);
    chk("R2 read next addr", rx, 8'h00);
    cs_end();
    cs_begin();
    xfer(8'h81, 8, rx, oa, ol);
    xfer(8'h00, 8, rx, oa, ol);
    chk("R2 msb first read", rx, model[1]);
    cs_end();
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_single_write();
    t_single_read();
    t_burst_write();
    t_burst_read();
    t_abort();
    t_dummy_direct();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule